// File: doc/BRIEF.md
# Four-Core Snooping MESI Coherence Controller

This block keeps the private caches of four cores coherent over one shared snoop bus. Each cache holds a handful of direct-mapped lines. Each line has a tag, a one-word data field and a two-bit coherence state. Cores present load, store and evict requests. A round-robin arbiter admits one request at a time. The controller then decides one of two outcomes. The request may complete locally: a hit, a silent upgrade from exclusive to modified, or a clean eviction. Otherwise the controller places a read or a read-for-ownership on the bus.

On a read, every other cache is snooped in the same cycle. A dirty owner forwards its word, writes it back to the memory array and drops to shared. Any clean holders also drop to shared. The requester fills as shared, or as exclusive when nobody else holds the line. On a read-for-ownership, every other valid copy must acknowledge before the requester may write. The acknowledgements arrive one per cycle, and each copy is invalidated as it acknowledges. The requester becomes modified only when the last acknowledgement lands.

A probe port reports, for any address, the state each cache holds. This lets the surrounding logic or a test observe coherence directly.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: State codes are Invalid=2'b00, Shared=2'b01, Exclusive=2'b10 and Modified=2'b11. `probe_state[2c+1:2c]` shows cache c's state for the line of `probe_addr`, or Invalid when the tag differs. After reset every cache reports Invalid, `done` is zero and `bus_valid` is low.
- R2: A line covers 64 bytes. Addresses that differ only in bits [5:0] reach the same line in every cache. Bits [7:6] select the cache slot and bits [11:8] form the tag.
- R3: A load that misses, with no other valid copy anywhere, fills Exclusive from memory. `done` rises 3 clock edges after the edge that first samples the request. A load hit completes in 2 edges with no bus transaction.
- R4: A load miss while other caches hold clean copies fills Shared with the memory word. Every Exclusive holder drops to Shared.
- R5: A load miss that snoops a Modified owner returns the owner's word. The owner drops to Shared and the requester fills Shared. The word is written back to memory.
- R6: A store to a line held Exclusive or Modified writes locally and ends Modified. It completes in 2 edges and `bus_valid` never rises.
- R7: A store to a line held Shared or Invalid raises `bus_valid` with `bus_rfo`. It completes 3+N edges after sampling, where N is the number of other caches holding a valid copy. Every such copy ends Invalid and the requester ends Modified holding the store word.
- R8: For every address, a cache holding Modified or Exclusive implies that no other cache holds a valid copy.
- R9: When several cores request together, grants rotate round-robin starting after the last granted core, with core 0 first after reset. A core keeps its request up until its `done`, and at most one `done` bit is high at a time.
- R10: Evicting a Modified line writes its word to memory and leaves it Invalid. Evicting an Exclusive or Shared line just invalidates it, with no bus transaction. Either case completes in 2 edges.
- R11: A load returns the word of the most recently completed store to that line, whichever core made it.
- R12: A miss whose slot holds a Modified line of another tag writes that victim to memory before the fill.
- R13: `done` is a one-cycle pulse, and for a load `rdata` of that core carries the result while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 4 | Per-core request pending |
| req_op | input | 8 | Per-core operation, 2 bits each: 0 load, 1 store, 2 evict |
| req_addr | input | 48 | Per-core byte address, 12 bits each |
| req_wdata | input | 128 | Per-core store word, 32 bits each |
| done | output | 4 | Per-core completion pulse |
| rdata | output | 128 | Per-core load result, 32 bits each |
| bus_valid | output | 1 | A snoop transaction occupies the bus |
| bus_rfo | output | 1 | The bus transaction is a read-for-ownership |
| bus_addr | output | 12 | Address of the current transaction |
| probe_addr | input | 12 | Address whose coherence state is reported |
| probe_state | output | 8 | Per-cache state for `probe_addr`, 2 bits each |

## Verification
Several properties are checked on every clock edge:
- the single-writer/multi-reader invariant, at both the bus address and the probe address;
- the one-hot, pulse-shaped and request-backed nature of `done`;
- that a read-for-ownership always rides on a valid bus cycle;
- that the acknowledgement count never reaches its target while still waiting;
- that silent upgrades leave the bus idle.

Other behaviour only shows in the bench's scenarios, which drive sequences of loads, stores and evictions across cores:
- the returned data and the writebacks;
- the exact final states of each cache;
- latencies that grow with the sharer count;
- the rotation order of simultaneous requests.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    parameter int NCORE  = 4;
    parameter int ADDR_W = 12;
    parameter int DATA_W = 32;
    parameter int OFF_W  = 6;
    parameter int NLINE  = 4;

    localparam int LINE_W    = ADDR_W - OFF_W;
    localparam int IDX_W     = $clog2(NLINE);
    localparam int TAG_W     = LINE_W - IDX_W;
    localparam int CORE_W    = $clog2(NCORE);
    localparam int CNT_W     = $clog2(NCORE + 1);
    localparam int MEM_DEPTH = 1 << LINE_W;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_LOOK  = 3'd1,
        FS_SNOOP = 3'd2,
        FS_ACK   = 3'd3,
        FS_DONE  = 3'd4
    } fsm_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        mesi_e             st;
        logic [DATA_W-1:0] data;
    } line_t;

    function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[OFF_W+IDX_W-1:OFF_W];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W+IDX_W];
    endfunction

    function automatic logic is_valid(input mesi_e s);
        return s != ST_I;
    endfunction

endpackage

// File: rtl/mesi_rr_arb.sv
module mesi_rr_arb
    import mesi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCORE-1:0]  req,
    input  logic              advance,
    output logic [CORE_W-1:0] grant_idx,
    output logic              grant_any
);

    logic [CORE_W-1:0] prio;

    // Scan from the priority pointer upward, wrapping once.
    always_comb begin
        grant_idx = '0;
        grant_any = 1'b0;
        for (int off = 0; off < NCORE; off++) begin
            int c;
            c = (int'(prio) + off) % NCORE;
            if (!grant_any && req[c]) begin
                grant_idx = CORE_W'(c);
                grant_any = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio <= '0;
        end else if (advance && grant_any) begin
            prio <= CORE_W'((int'(grant_idx) + 1) % NCORE);
        end
    end

endmodule

// File: rtl/mesi_cache_bank.sv
module mesi_cache_bank
    import mesi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  line_t             upd_line,
    output mesi_e             lk_st,
    output logic [DATA_W-1:0] lk_data,
    output line_t             slot,
    output mesi_e             probe_st
);

    line_t ent [NLINE];
    line_t pslot;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINE; i++) begin
                ent[i] <= '{tag: '0, st: ST_I, data: '0};
            end
        end else if (upd_en) begin
            ent[upd_idx] <= upd_line;
        end
    end

    // Tag-qualified lookups for the bus address and the probe address.
    always_comb begin
        slot    = ent[idx_of(lk_addr)];
        lk_st   = (is_valid(slot.st) && slot.tag == tag_of(lk_addr)) ? slot.st : ST_I;
        lk_data = slot.data;
        pslot   = ent[idx_of(probe_addr)];
        probe_st = (is_valid(pslot.st) && pslot.tag == tag_of(probe_addr)) ? pslot.st : ST_I;
    end

endmodule

// File: rtl/mesi_mem.sv
module mesi_mem
    import mesi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] rd_line,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] words [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[wr_line] <= wr_data;
        end
    end

    assign rd_data = words[rd_line];

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCORE-1:0]          req_valid,
    input  logic [2*NCORE-1:0]        req_op,
    input  logic [NCORE*ADDR_W-1:0]   req_addr,
    input  logic [NCORE*DATA_W-1:0]   req_wdata,
    output logic [NCORE-1:0]          done,
    output logic [NCORE*DATA_W-1:0]   rdata,
    output logic                      bus_valid,
    output logic                      bus_rfo,
    output logic [ADDR_W-1:0]         bus_addr,
    input  logic [ADDR_W-1:0]         probe_addr,
    output logic [2*NCORE-1:0]        probe_state
);

    // Transaction registers
    fsm_e              fsm;
    logic [CORE_W-1:0] cur_core;
    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [NCORE-1:0]  ack_pend;
    logic [CNT_W-1:0]  ack_need;
    logic [CNT_W-1:0]  ack_cnt;
    logic [NCORE-1:0]  done_r;
    logic [DATA_W-1:0] rdata_r [NCORE];
    logic              bus_valid_r;
    logic              bus_rfo_r;

    // Per-cache views and update ports
    mesi_e             lk_st    [NCORE];
    logic [DATA_W-1:0] lk_data  [NCORE];
    line_t             slot     [NCORE];
    mesi_e             probe_st [NCORE];
    logic [NCORE-1:0]  upd_en;
    line_t             upd_line [NCORE];
    logic [2*NCORE-1:0] bus_state;

    // Memory port
    logic [DATA_W-1:0] mem_rd_data;
    logic              mem_we;
    logic [LINE_W-1:0] mem_wline;
    logic [DATA_W-1:0] mem_wdata;

    // Arbiter
    logic [CORE_W-1:0] grant_idx;
    logic              grant_any;
    logic              arb_adv;

    // Decisions
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    mesi_e             own_st;
    line_t             own_slot;
    logic [NCORE-1:0]  oth_v;
    logic [NCORE-1:0]  oth_m;
    logic [DATA_W-1:0] owner_data;
    logic [CORE_W-1:0] ack_pick;
    logic              complete;
    logic              go_snoop;
    logic              go_ack;
    logic [DATA_W-1:0] ret_data;

    assign cur_idx  = idx_of(cur_addr);
    assign cur_tag  = tag_of(cur_addr);
    assign own_st   = lk_st[cur_core];
    assign own_slot = slot[cur_core];
    assign arb_adv  = (fsm == FS_IDLE) && grant_any;

    mesi_rr_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req_valid),
        .advance   (arb_adv),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    mesi_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_line (line_of(cur_addr)),
        .rd_data (mem_rd_data),
        .wr_en   (mem_we),
        .wr_line (mem_wline),
        .wr_data (mem_wdata)
    );

    for (genvar g = 0; g < NCORE; g++) begin : g_bank
        mesi_cache_bank u_bank (
            .clk        (clk),
            .rst        (rst),
            .lk_addr    (cur_addr),
            .probe_addr (probe_addr),
            .upd_en     (upd_en[g]),
            .upd_idx    (cur_idx),
            .upd_line   (upd_line[g]),
            .lk_st      (lk_st[g]),
            .lk_data    (lk_data[g]),
            .slot       (slot[g]),
            .probe_st   (probe_st[g])
        );
        assign probe_state[2*g +: 2]     = probe_st[g];
        assign bus_state[2*g +: 2]       = lk_st[g];
        assign rdata[g*DATA_W +: DATA_W] = rdata_r[g];
    end

    // Snoop results of every cache other than the requester
    always_comb begin
        oth_v      = '0;
        oth_m      = '0;
        owner_data = '0;
        ack_pick   = '0;
        for (int c = 0; c < NCORE; c++) begin
            oth_v[c] = (c != int'(cur_core)) && is_valid(lk_st[c]);
            oth_m[c] = (c != int'(cur_core)) && (lk_st[c] == ST_M);
            if (oth_m[c]) owner_data = owner_data | lk_data[c];
        end
        for (int c = NCORE - 1; c >= 0; c--) begin
            if (ack_pend[c]) ack_pick = CORE_W'(c);
        end
    end

    // Per-state decisions: cache updates, memory writes, completion
    always_comb begin
        upd_en    = '0;
        mem_we    = 1'b0;
        mem_wline = line_of(cur_addr);
        mem_wdata = '0;
        complete  = 1'b0;
        go_snoop  = 1'b0;
        go_ack    = 1'b0;
        ret_data  = '0;
        for (int c = 0; c < NCORE; c++) upd_line[c] = slot[c];

        case (fsm)
            FS_LOOK: begin
                case (cur_op)
                    OP_LOAD, OP_STORE: begin
                        if (cur_op == OP_LOAD && is_valid(own_st)) begin
                            complete = 1'b1;
                            ret_data = lk_data[cur_core];
                        end else if (cur_op == OP_STORE && (own_st == ST_M || own_st == ST_E)) begin
                            upd_en[cur_core]   = 1'b1;
                            upd_line[cur_core] = '{tag: cur_tag, st: ST_M, data: cur_wdata};
                            complete = 1'b1;
                        end else begin
                            // Dirty line of another tag in the slot: write it back first.
                            if (own_st == ST_I && own_slot.st == ST_M) begin
                                mem_we    = 1'b1;
                                mem_wline = {own_slot.tag, cur_idx};
                                mem_wdata = own_slot.data;
                                upd_en[cur_core]   = 1'b1;
                                upd_line[cur_core] = '{tag: own_slot.tag, st: ST_I, data: own_slot.data};
                            end
                            go_snoop = 1'b1;
                        end
                    end
                    OP_EVICT: begin
                        if (own_st == ST_M) begin
                            mem_we    = 1'b1;
                            mem_wdata = lk_data[cur_core];
                        end
                        if (is_valid(own_st)) begin
                            upd_en[cur_core]   = 1'b1;
                            upd_line[cur_core] = '{tag: cur_tag, st: ST_I, data: own_slot.data};
                        end
                        complete = 1'b1;
                    end
                    default: complete = 1'b1;
                endcase
            end

            FS_SNOOP: begin
                if (!bus_rfo_r) begin
                    if (|oth_m) begin
                        mem_we    = 1'b1;
                        mem_wdata = owner_data;
                        ret_data  = owner_data;
                        for (int c = 0; c < NCORE; c++) begin
                            if (oth_m[c]) begin
                                upd_en[c]   = 1'b1;
                                upd_line[c] = '{tag: cur_tag, st: ST_S, data: lk_data[c]};
                            end
                        end
                        upd_line[cur_core] = '{tag: cur_tag, st: ST_S, data: owner_data};
                    end else begin
                        ret_data = mem_rd_data;
                        for (int c = 0; c < NCORE; c++) begin
                            if (oth_v[c] && lk_st[c] == ST_E) begin
                                upd_en[c]   = 1'b1;
                                upd_line[c] = '{tag: cur_tag, st: ST_S, data: lk_data[c]};
                            end
                        end
                        upd_line[cur_core] = '{tag: cur_tag, st: (|oth_v) ? ST_S : ST_E,
                                               data: mem_rd_data};
                    end
                    upd_en[cur_core] = 1'b1;
                    complete = 1'b1;
                end else if (oth_v == '0) begin
                    upd_en[cur_core]   = 1'b1;
                    upd_line[cur_core] = '{tag: cur_tag, st: ST_M, data: cur_wdata};
                    complete = 1'b1;
                end else begin
                    go_ack = 1'b1;
                end
            end

            FS_ACK: begin
                // One sharer acknowledges per cycle and drops its copy.
                upd_en[ack_pick]   = 1'b1;
                upd_line[ack_pick] = '{tag: slot[ack_pick].tag, st: ST_I,
                                       data: slot[ack_pick].data};
                if (ack_cnt + CNT_W'(1) == ack_need) begin
                    upd_en[cur_core]   = 1'b1;
                    upd_line[cur_core] = '{tag: cur_tag, st: ST_M, data: cur_wdata};
                    complete = 1'b1;
                end
            end

            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm         <= FS_IDLE;
            cur_core    <= '0;
            cur_op      <= OP_NONE;
            cur_addr    <= '0;
            cur_wdata   <= '0;
            ack_pend    <= '0;
            ack_need    <= '0;
            ack_cnt     <= '0;
            done_r      <= '0;
            bus_valid_r <= 1'b0;
            bus_rfo_r   <= 1'b0;
            for (int c = 0; c < NCORE; c++) rdata_r[c] <= '0;
        end else begin
            case (fsm)
                FS_IDLE: begin
                    if (grant_any) begin
                        cur_core  <= grant_idx;
                        cur_op    <= op_e'(req_op[2*grant_idx +: 2]);
                        cur_addr  <= req_addr[ADDR_W*grant_idx +: ADDR_W];
                        cur_wdata <= req_wdata[DATA_W*grant_idx +: DATA_W];
                        fsm       <= FS_LOOK;
                    end
                end
                FS_LOOK: begin
                    if (go_snoop) begin
                        bus_valid_r <= 1'b1;
                        bus_rfo_r   <= (cur_op == OP_STORE);
                        fsm         <= FS_SNOOP;
                    end
                end
                FS_SNOOP: begin
                    if (go_ack) begin
                        ack_pend <= oth_v;
                        ack_need <= CNT_W'($countones(oth_v));
                        ack_cnt  <= '0;
                        fsm      <= FS_ACK;
                    end
                end
                FS_ACK: begin
                    ack_pend[ack_pick] <= 1'b0;
                    ack_cnt            <= ack_cnt + CNT_W'(1);
                end
                FS_DONE: begin
                    done_r <= '0;
                    fsm    <= FS_IDLE;
                end
                default: fsm <= FS_IDLE;
            endcase

            if (complete) begin
                done_r[cur_core] <= 1'b1;
                bus_valid_r      <= 1'b0;
                bus_rfo_r        <= 1'b0;
                fsm              <= FS_DONE;
                if (cur_op == OP_LOAD) rdata_r[cur_core] <= ret_data;
            end
        end
    end

    assign done      = done_r;
    assign bus_valid = bus_valid_r;
    assign bus_rfo   = bus_rfo_r;
    assign bus_addr  = cur_addr;

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk
    import mesi_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NCORE-1:0]   done,
    input logic [NCORE-1:0]   req_valid,
    input logic               bus_valid,
    input logic               bus_rfo,
    input logic [2*NCORE-1:0] probe_state,
    input logic [2*NCORE-1:0] bus_state,
    input fsm_e               fsm,
    input op_e                cur_op,
    input mesi_e              own_st,
    input logic [CNT_W-1:0]   ack_cnt,
    input logic [CNT_W-1:0]   ack_need
);

    function automatic int n_excl(input logic [2*NCORE-1:0] v);
        int n = 0;
        for (int c = 0; c < NCORE; c++) begin
            if (v[2*c +: 2] == ST_M || v[2*c +: 2] == ST_E) n++;
        end
        return n;
    endfunction

    function automatic int n_valid(input logic [2*NCORE-1:0] v);
        int n = 0;
        for (int c = 0; c < NCORE; c++) begin
            if (v[2*c +: 2] != ST_I) n++;
        end
        return n;
    endfunction

    // R8: single writer or many readers, seen at the bus address
    p_swmr_bus_r8: assert property (@(posedge clk) disable iff (rst)
        (n_excl(bus_state) != 0) |-> (n_valid(bus_state) == 1));

    // R8: same invariant at whatever address is probed
    p_swmr_probe_r8: assert property (@(posedge clk) disable iff (rst)
        (n_excl(probe_state) != 0) |-> (n_valid(probe_state) == 1));

    // R9: one completion at a time
    p_done_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));

    // R9: completion only for a core that was requesting
    p_done_req_r9: assert property (@(posedge clk) disable iff (rst)
        ((done & ~$past(req_valid)) == '0));

    // R13: completion lasts a single cycle
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        (|done) |=> (done == '0));

    // R7: ownership requests only on a live bus cycle
    p_rfo_bus_r7: assert property (@(posedge clk) disable iff (rst)
        bus_rfo |-> bus_valid);

    // R7: still waiting means fewer acknowledgements than sharers
    p_ack_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (fsm == FS_ACK) |-> (ack_cnt < ack_need));

    // R6: a store on an owned line keeps the bus idle
    p_silent_store_r6: assert property (@(posedge clk) disable iff (rst)
        (fsm == FS_LOOK && cur_op == OP_STORE && (own_st == ST_M || own_st == ST_E))
        |=> !bus_valid);

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .req_valid   (req_valid),
    .bus_valid   (bus_valid),
    .bus_rfo     (bus_rfo),
    .probe_state (probe_state),
    .bus_state   (bus_state),
    .fsm         (fsm),
    .cur_op      (cur_op),
    .own_st      (own_st),
    .ack_cnt     (ack_cnt),
    .ack_need    (ack_need)
);

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   req_valid;
    logic [7:0]   req_op;
    logic [47:0]  req_addr;
    logic [127:0] req_wdata;
    logic [3:0]   done;
    logic [127:0] rdata;
    logic         bus_valid;
    logic         bus_rfo;
    logic [11:0]  bus_addr;
    logic [11:0]  probe_addr;
    logic [7:0]   probe_state;

    int n_checks = 0;
    int n_bad    = 0;

    always #5 clk = ~clk;

    mesi_snoop_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .done        (done),
        .rdata       (rdata),
        .bus_valid   (bus_valid),
        .bus_rfo     (bus_rfo),
        .bus_addr    (bus_addr),
        .probe_addr  (probe_addr),
        .probe_state (probe_state)
    );

    localparam logic [1:0] LD = 2'd0;
    localparam logic [1:0] ST = 2'd1;
    localparam logic [1:0] EV = 2'd2;

    localparam logic [11:0] A = 12'h040;
    localparam logic [11:0] B = 12'h080;
    localparam logic [11:0] C = 12'h140;
    localparam logic [11:0] D = 12'h0C0;

    typedef struct packed {
        logic [1:0]  core;
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] edata;
        logic [3:0]  lat;
        logic [7:0]  probe;
        logic        bus;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, LD, A,          32'h0,        32'h0,        4'd3, 8'h02, 1'b1, 4'd3},  // R3 miss to E
        '{2'd0, LD, A + 12'h3C, 32'h0,        32'h0,        4'd2, 8'h02, 1'b0, 4'd2},  // R2 same line hit
        '{2'd0, ST, A,          32'h11111111, 32'h0,        4'd2, 8'h03, 1'b0, 4'd6},  // R6 E to M silent
        '{2'd1, LD, A + 12'h04, 32'h0,        32'h11111111, 4'd3, 8'h05, 1'b1, 4'd5},  // R5 owner forwards
        '{2'd2, LD, A,          32'h0,        32'h11111111, 4'd3, 8'h15, 1'b1, 4'd4},  // R4 shared fill from memory
        '{2'd3, ST, A,          32'h22222222, 32'h0,        4'd6, 8'hC0, 1'b1, 4'd7},  // R7 three acks
        '{2'd0, LD, A,          32'h0,        32'h22222222, 4'd3, 8'h41, 1'b1, 4'd11}, // R11 latest store
        '{2'd0, ST, A,          32'h33333333, 32'h0,        4'd4, 8'h03, 1'b1, 4'd7},  // R7 one ack, S to M
        '{2'd1, LD, B,          32'h0,        32'h0,        4'd3, 8'h08, 1'b1, 4'd3},  // R3 miss to E
        '{2'd2, LD, B,          32'h0,        32'h0,        4'd3, 8'h14, 1'b1, 4'd4},  // R4 E holder drops
        '{2'd2, ST, B,          32'h44444444, 32'h0,        4'd4, 8'h30, 1'b1, 4'd7},  // R7 one ack
        '{2'd2, EV, B,          32'h0,        32'h0,        4'd2, 8'h00, 1'b0, 4'd10}, // R10 dirty evict
        '{2'd1, LD, B,          32'h0,        32'h44444444, 4'd3, 8'h08, 1'b1, 4'd10}, // R10 writeback seen
        '{2'd1, EV, B,          32'h0,        32'h0,        4'd2, 8'h00, 1'b0, 4'd10}, // R10 clean evict
        '{2'd0, LD, C,          32'h0,        32'h0,        4'd3, 8'h02, 1'b1, 4'd12}, // R12 victim of A
        '{2'd3, LD, A,          32'h0,        32'h33333333, 4'd3, 8'h80, 1'b1, 4'd12}, // R12 victim reached memory
        '{2'd3, ST, A + 12'h08, 32'h55555555, 32'h0,        4'd2, 8'hC0, 1'b0, 4'd6},  // R6 silent
        '{2'd0, ST, D,          32'h66666666, 32'h0,        4'd3, 8'h03, 1'b1, 4'd7},  // R7 no sharers
        '{2'd0, LD, D,          32'h0,        32'h66666666, 4'd2, 8'h03, 1'b0, 4'd11}  // R11 hit own store
    };

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic bit swmr_ok(input logic [7:0] v);
        int ex = 0;
        int va = 0;
        for (int c = 0; c < 4; c++) begin
            if (v[2*c +: 2] >= 2'd2) ex++;
            if (v[2*c +: 2] != 2'd0) va++;
        end
        return (ex == 0) || (va == 1);
    endfunction

    task automatic probe(input logic [11:0] a, output logic [7:0] st);
        probe_addr = a;
        #1;
        st = probe_state;
    endtask

    // Issue one request at a negedge; returns the data, the latency in edges
    // and whether the bus was seen busy. Ends one negedge after done.
    task automatic do_op(input int core, input logic [1:0] op, input logic [11:0] addr,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output int lat, output bit saw_bus);
        req_op[core*2 +: 2]     = op;
        req_addr[core*12 +: 12] = addr;
        req_wdata[core*32 +: 32] = wd;
        req_valid[core]         = 1'b1;
        lat     = 0;
        saw_bus = 1'b0;
        rd      = '0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            lat++;
            if (bus_valid) saw_bus = 1'b1;
            if (done[core]) break;
        end
        if (!done[core]) chk(1'b0, "R9 request never completed", 32'(done), 32'(1 << core));
        rd = rdata[core*32 +: 32];
        req_valid[core] = 1'b0;
        @(negedge clk);
        chk(done == 4'b0, "R13 done pulse width", 32'(done), 32'h0);
    endtask

    initial begin
        #(200_000 * 10);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          lat;
        bit          sb;
        logic [7:0]  st;
        int          order [4];
        logic [31:0] got   [4];
        int          n_done;

        rst        = 1'b1;
        req_valid  = '0;
        req_op     = '1;
        req_addr   = '0;
        req_wdata  = '0;
        probe_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        probe(A, st);
        chk(st == 8'h00, "R1 reset probe A", 32'(st), 32'h0);
        probe(C, st);
        chk(st == 8'h00, "R1 reset probe C", 32'(st), 32'h0);
        chk(done == 4'b0, "R1 reset done", 32'(done), 32'h0);
        chk(bus_valid == 1'b0, "R1 reset bus idle", 32'(bus_valid), 32'h0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            do_op(int'(VECS[v].core), VECS[v].op, VECS[v].addr, VECS[v].wdata, rd, lat, sb);
            if (VECS[v].op == LD) begin
                chk(rd == VECS[v].edata,
                    $sformatf("vector %0d R%0d load data", v, VECS[v].req), rd, VECS[v].edata);
            end
            chk(lat == int'(VECS[v].lat),
                $sformatf("vector %0d R%0d latency", v, VECS[v].req), 32'(lat), 32'(VECS[v].lat));
            chk(sb == VECS[v].bus,
                $sformatf("vector %0d R%0d bus use", v, VECS[v].req), 32'(sb), 32'(VECS[v].bus));
            probe(VECS[v].addr, st);
            chk(st == VECS[v].probe,
                $sformatf("vector %0d R%0d R1 states", v, VECS[v].req), 32'(st), 32'(VECS[v].probe));
            chk(swmr_ok(st), $sformatf("vector %0d R8 invariant", v), 32'(st), 32'(VECS[v].probe));
        end

        // R12: the C fill left A out of core 0 and memory got the victim
        probe(C, st);
        chk(st == 8'h02, "R12 C still Exclusive in core 0", 32'(st), 32'h02);

        // R9: four simultaneous requests; last grant was core 0, so 1,2,3,0
        req_op    = {LD, LD, LD, LD};
        req_addr  = {A + 12'h20, A, D + 12'h10, D};
        req_wdata = '0;
        @(negedge clk);
        req_valid = 4'b1111;
        n_done = 0;
        for (int k = 0; k < 80 && n_done < 4; k++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                if (done[c]) begin
                    order[n_done] = c;
                    got[c]        = rdata[c*32 +: 32];
                    n_done++;
                    req_valid[c]  = 1'b0;
                end
            end
        end
        chk(n_done == 4, "R9 all four completed", 32'(n_done), 32'd4);
        chk(order[0] == 1, "R9 first grant", 32'(order[0]), 32'd1);
        chk(order[1] == 2, "R9 second grant", 32'(order[1]), 32'd2);
        chk(order[2] == 3, "R9 third grant", 32'(order[2]), 32'd3);
        chk(order[3] == 0, "R9 fourth grant", 32'(order[3]), 32'd0);
        chk(got[1] == 32'h66666666, "R5 core 1 D from owner", got[1], 32'h66666666);
        chk(got[2] == 32'h55555555, "R5 core 2 A from owner", got[2], 32'h55555555);
        chk(got[3] == 32'h55555555, "R11 core 3 A hit", got[3], 32'h55555555);
        chk(got[0] == 32'h66666666, "R11 core 0 D hit", got[0], 32'h66666666);
        @(negedge clk);
        probe(A, st);
        chk(st == 8'h50, "R5 A shared by cores 2 and 3", 32'(st), 32'h50);
        chk(swmr_ok(st), "R8 invariant A after burst", 32'(st), 32'h50);
        probe(D, st);
        chk(st == 8'h05, "R5 D shared by cores 0 and 1", 32'(st), 32'h05);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

endmodule